// File: doc/BRIEF.md
# Full-Duplex Clock-Synchronous Serial Transceiver

This block moves 8-bit frames in both directions at once over one serial clock that it generates itself as clock master. Software reaches it through a small register bus. There is a transmit buffer, a receive buffer, a mode register holding the two direction enables, a baud divider and a flag register. The flag register carries transmit-empty, receive-full and overrun. Software hands a byte to the shifter by writing the transmit buffer and then clearing transmit-empty. It takes a received byte by reading the receive buffer and then clearing receive-full.

Each flag clears only when software writes a 0 to its bit after a read of the flag register has returned that bit as 1. A completed frame that arrives while receive-full is still set raises overrun. Overrun stops all further frames in both directions until software clears it. Two one-cycle interrupt pulses mark a 0-to-1 change of transmit-empty and of receive-full.

Register offsets on the 3-bit address: 0 transmit buffer (write, reads back), 1 receive buffer (read), 2 mode (bit 0 transmit enable, bit 1 receive enable), 3 flags (bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun), 4 baud divider N.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the flags read 8'h01 (only transmit-empty set), both enables read 0, the serial clock is high and neither interrupt pulses.
- R2: A flag bit clears only on a write of 0 to offset 3 that follows a read (rdEn high at offset 3) returning that bit as 1. Writing 1, or writing 0 without such a read, leaves the flag unchanged. The transmit buffer reads back the last byte written.
- R3: With transmit enabled, clearing transmit-empty starts a frame that sends the transmit buffer least-significant bit first. txd changes on falling serial-clock edges, and transmit-empty is set again when the byte enters the shifter.
- R4: rxd is sampled on rising serial-clock edges, least-significant bit first. With receive enabled and receive-full clear, the frame's byte lands in the receive buffer at frame end and receive-full is set.
- R5: The serial clock idles high. Within a frame each high and each low phase lasts N+1 system clocks, so the period is 2*(N+1).
- R6: txIrq and rxIrq are single-cycle pulses, one for every 0-to-1 change of transmit-empty and of receive-full respectively.
- R7: A frame that ends while receive-full is set sets overrun, discards the new byte and keeps the old one in the receive buffer. While overrun is set, no frame starts in either direction.
- R8: If the next byte is handed over before the current frame ends, the next frame's first falling edge follows the current frame's first falling edge by exactly 16*(N+1)+2 system clocks. Otherwise the serial clock stays high.
- R9: With receive enabled and transmit disabled, frames run back to back without any handover, so an unread byte leads to overrun on the following frame.
- R10: A mode write that would turn on both enables while exactly one is on is ignored as a whole. From both-off, both can be set in one write.
- R11: An accepted mode write that clears an enable stops a running frame at once with the serial clock high. Clearing transmit enable sets transmit-empty. Receive-full and overrun are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 3 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| sck | output | 1 | Serial clock, idle high |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| txIrq | output | 1 | Transmit-empty rise pulse |
| rxIrq | output | 1 | Receive-full rise pulse |

## Verification
The properties assume that the bus strobes and rxd hold known values once reset is released. They also assume that rxd never moves in the same system cycle as a rising serial-clock edge. The bench keeps to this in two ways. A slave model changes rxd only on falling serial-clock edges. Every register access is driven on the falling system-clock edge, one access at a time, and always begins with reset asserted.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_TXBUF = 3'd0;
  localparam logic [ADDR_W-1:0] REG_RXBUF = 3'd1;
  localparam logic [ADDR_W-1:0] REG_MODE  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_FLAGS = 3'd3;
  localparam logic [ADDR_W-1:0] REG_BAUD  = 3'd4;

  localparam int NUM_FLAGS = 3;
  localparam int FLAG_TXE  = 0;
  localparam int FLAG_RXF  = 1;
  localparam int FLAG_OVR  = 2;

  typedef struct packed {
    logic start;
    logic loadTx;
    logic abort;
  } ssxStrobe_t;
endpackage

// File: rtl/ssx_ctl.sv
module ssx_ctl
  import ssx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  dpBusy,
  input  logic                  dpDone,
  input  logic [DATA_W-1:0]     dpRxByte,
  output ssxStrobe_t            strobe,
  output logic [DATA_W-1:0]     txByte,
  output logic [DIV_W-1:0]      divider,
  output logic                  txIrq,
  output logic                  rxIrq,
  output logic                  txEn,
  output logic                  rxEn,
  output logic [NUM_FLAGS-1:0]  flags,
  output logic [DATA_W-1:0]     rxHold
);
  localparam logic [NUM_FLAGS-1:0] FLAG_INIT = NUM_FLAGS'(1 << FLAG_TXE);

  logic                 te, re;
  logic [NUM_FLAGS-1:0] flag, flagD, armed;
  logic [NUM_FLAGS-1:0] setF, clrF;
  logic [DATA_W-1:0]    tdr, rdr;
  logic [DIV_W-1:0]     divReg;
  logic                 modeWr, modeAcc, newTe, newRe, flagWr, flagRd;
  logic                 startC, abortC, rxTake;

  always_comb begin
    modeWr  = wrEn && (addr == REG_MODE);
    newTe   = wrData[0];
    newRe   = wrData[1];
    // going from exactly one enable to both is refused
    modeAcc = modeWr && !(newTe && newRe && (te ^ re));
    abortC  = modeAcc && dpBusy && ((te && !newTe) || (re && !newRe));
    startC  = !dpBusy && !dpDone && !flag[FLAG_OVR] && !modeWr &&
              ((te && !flag[FLAG_TXE]) || (!te && re));
    rxTake  = dpDone && re;
    flagWr  = wrEn && (addr == REG_FLAGS);
    flagRd  = rdEn && (addr == REG_FLAGS);
    for (int i = 0; i < NUM_FLAGS; i++) begin
      clrF[i] = flagWr && !wrData[i] && armed[i] && flag[i];
    end
    setF             = '0;
    setF[FLAG_TXE]   = (modeAcc && !newTe) || (startC && te);
    setF[FLAG_RXF]   = rxTake && !flag[FLAG_RXF];
    setF[FLAG_OVR]   = rxTake && flag[FLAG_RXF];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      te     <= 1'b0;
      re     <= 1'b0;
      flag   <= FLAG_INIT;
      flagD  <= FLAG_INIT;
      armed  <= '0;
      tdr    <= '0;
      rdr    <= '0;
      divReg <= DIV_W'(DIV_RESET);
    end else begin
      if (modeAcc) begin
        te <= newTe;
        re <= newRe;
      end
      if (wrEn && (addr == REG_TXBUF)) tdr <= wrData;
      if (wrEn && (addr == REG_BAUD))  divReg <= wrData[DIV_W-1:0];
      if (rxTake && !flag[FLAG_RXF])   rdr <= dpRxByte;
      flag  <= setF | (flag & ~clrF);
      flagD <= flag;
      for (int i = 0; i < NUM_FLAGS; i++) begin
        if (clrF[i])                 armed[i] <= 1'b0;
        else if (flagRd && flag[i])  armed[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      REG_TXBUF: rdData = tdr;
      REG_RXBUF: rdData = rdr;
      REG_MODE:  rdData[1:0] = {re, te};
      REG_FLAGS: rdData[NUM_FLAGS-1:0] = flag;
      REG_BAUD:  rdData[DIV_W-1:0] = divReg;
      default:   rdData = '0;
    endcase
  end

  assign strobe.start  = startC;
  assign strobe.loadTx = te;
  assign strobe.abort  = abortC;
  assign txByte  = tdr;
  assign divider = divReg;
  assign txIrq   = flag[FLAG_TXE] & ~flagD[FLAG_TXE];
  assign rxIrq   = flag[FLAG_RXF] & ~flagD[FLAG_RXF];
  assign txEn    = te;
  assign rxEn    = re;
  assign flags   = flag;
  assign rxHold  = rdr;
endmodule

// File: rtl/ssx_dp.sv
module ssx_dp
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ssxStrobe_t        strobe,
  input  logic [DATA_W-1:0] txByte,
  input  logic [DIV_W-1:0]  divider,
  input  logic              rxd,
  output logic              sck,
  output logic              txd,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxByte
);
  localparam int HALVES = 2 * DATA_W;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

  logic [HW-1:0]     halfIdx;
  logic [DIV_W-1:0]  divCnt;
  logic [DATA_W-1:0] txSh, rxSh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck     <= 1'b1;
      txd     <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      halfIdx <= '0;
      divCnt  <= '0;
      txSh    <= '1;
      rxSh    <= '0;
    end else begin
      done <= 1'b0;
      if (strobe.abort) begin
        busy    <= 1'b0;
        sck     <= 1'b1;
        halfIdx <= '0;
        divCnt  <= '0;
      end else if (strobe.start) begin
        busy    <= 1'b1;
        sck     <= 1'b0;
        halfIdx <= '0;
        divCnt  <= '0;
        txd     <= strobe.loadTx ? txByte[0] : 1'b1;
        txSh    <= strobe.loadTx ? {1'b1, txByte[DATA_W-1:1]} : '1;
      end else if (busy) begin
        if (divCnt == divider) begin
          divCnt  <= '0;
          halfIdx <= halfIdx + 1'b1;
          if (!halfIdx[0]) begin
            sck  <= 1'b1;
            rxSh <= {rxd, rxSh[DATA_W-1:1]};
          end else if (halfIdx == LAST_HALF) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sck  <= 1'b0;
            txd  <= txSh[0];
            txSh <= {1'b1, txSh[DATA_W-1:1]};
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign rxByte = rxSh;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sck,
  output logic              txd,
  input  logic              rxd,
  output logic              txIrq,
  output logic              rxIrq
);
  ssxStrobe_t           strobe;
  logic [DATA_W-1:0]    txByte, rxByte, rxHold;
  logic [DIV_W-1:0]     divider;
  logic                 dpBusy, dpDone;
  logic                 ctlTxEn, ctlRxEn;
  logic [NUM_FLAGS-1:0] flagBits;

  ssx_ctl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_ctl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .dpBusy(dpBusy), .dpDone(dpDone),
    .dpRxByte(rxByte), .strobe(strobe), .txByte(txByte), .divider(divider),
    .txIrq(txIrq), .rxIrq(rxIrq), .txEn(ctlTxEn), .rxEn(ctlRxEn),
    .flags(flagBits), .rxHold(rxHold)
  );

  ssx_dp #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .txByte(txByte),
    .divider(divider), .rxd(rxd), .sck(sck), .txd(txd), .busy(dpBusy),
    .done(dpDone), .rxByte(rxByte)
  );
endmodule

// File: rtl/sync_serial_xcvr_chk.sv
module sync_serial_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sck,
  input logic              txIrq,
  input logic              rxIrq,
  input logic              txEn,
  input logic              rxEn,
  input logic [2:0]        flagBits,
  input logic [DATA_W-1:0] rxHold
);
  a_r6_txirq_single: assert property (@(posedge clk) disable iff (rst)
    txIrq |=> !txIrq);

  a_r6_rxirq_single: assert property (@(posedge clk) disable iff (rst)
    rxIrq |=> !rxIrq);

  a_r6_rxirq_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(flagBits[1]) |-> rxIrq);

  a_r7_overrun_idle: assert property (@(posedge clk) disable iff (rst)
    flagBits[2] |-> sck);

  a_r7_rxhold_kept: assert property (@(posedge clk) disable iff (rst)
    (flagBits[2] && $past(flagBits[2])) |-> $stable(rxHold));

  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    (!txEn && !rxEn) |-> sck);

  a_r10_no_half_enable: assert property (@(posedge clk) disable iff (rst)
    (txEn && rxEn) |-> ($past(txEn) == $past(rxEn)));
endmodule

bind sync_serial_xcvr sync_serial_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sck(sck), .txIrq(txIrq), .rxIrq(rxIrq),
  .txEn(ctlTxEn), .rxEn(ctlRxEn), .flagBits(flagBits), .rxHold(rxHold)
);

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       sck, txd, txIrq, rxIrq;
  logic       rxd = 1'b0;

  int checks = 0, errors = 0;
  int framesSeen = 0, fallCnt = 0, txIrqN = 0, rxIrqN = 0;
  int capN = 0, sBit = 0;
  longint tFall = 0, tFrame = 0, fallGap = 0, frameGap = 0;
  logic [7:0] capSh = '0, sCur = '0, slaveByte = 8'h3C, expRx, v;
  logic [7:0] txQ[$];

  always #4 clk = ~clk;

  sync_serial_xcvr u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sck(sck), .txd(txd), .rxd(rxd),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  // scoreboard driver: write byte, arm, clear transmit-empty
  task automatic handTx(input logic [7:0] b, input bit expectSent);
    logic [7:0] s;
    busWrite(3'd0, b);
    if (expectSent) txQ.push_back(b);
    busRead(3'd3, s);
    busWrite(3'd3, 8'h06);
  endtask

  task automatic waitFlag(input int bitPos);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      peek(3'd3, s);
      if (s[bitPos]) break;
    end
  endtask

  // monitor: assemble transmitted bits on rising sck, compare with queue
  always @(posedge sck) if (!rst) begin
    capSh = {txd, capSh[7:1]};
    capN++;
    if (capN == 8) begin
      capN = 0;
      framesSeen++;
      if (txQ.size() > 0) chk("R3 transmitted byte", capSh, txQ.pop_front());
    end
  end

  always @(negedge sck) if (!rst) begin
    if (capN != 0) fallGap = ($time - tFall) / 8;
    else begin
      frameGap = ($time - tFrame) / 8;
      tFrame = $time;
    end
    tFall = $time;
    fallCnt++;
  end

  // slave device: drives rxd on falling sck, new byte each frame
  always @(negedge sck) if (!rst) begin
    if (sBit == 0) sCur = slaveByte;
    rxd <= sCur[sBit];
    sBit++;
    if (sBit == 8) begin
      sBit = 0;
      slaveByte = slaveByte + 8'h11;
    end
  end

  always @(negedge clk) if (!rst) begin
    if (txIrq) txIrqN++;
    if (rxIrq) rxIrqN++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    peek(3'd3, v); chk("R1 flags", v, 8'h01);
    peek(3'd2, v); chk("R1 mode", v, 8'h00);
    chk("R1 sck idle", sck, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 no irq", txIrqN + rxIrqN, 0);

    // R2 clear rules and buffer readback
    busWrite(3'd3, 8'h00);
    peek(3'd3, v); chk("R2 unarmed write 0", v, 8'h01);
    busRead(3'd3, v);
    busWrite(3'd3, 8'h07);
    peek(3'd3, v); chk("R2 write 1 ignored", v, 8'h01);
    busWrite(3'd0, 8'h5A);
    peek(3'd0, v); chk("R2 tx buffer readback", v, 8'h5A);

    // R10 enable switching
    busWrite(3'd2, 8'h01);
    busWrite(3'd2, 8'h03);
    peek(3'd2, v); chk("R10 half enable ignored", v, 8'h01);
    busWrite(3'd2, 8'h00);
    busWrite(3'd2, 8'h03);
    peek(3'd2, v); chk("R10 both from off", v, 8'h03);

    // R3 R4 R5 R6 single duplex frame, N=2
    busWrite(3'd4, 8'h02);
    expRx = slaveByte;
    handTx(8'hA5, 1'b1);
    waitFlag(1);
    peek(3'd1, v); chk("R4 received byte", v, expRx);
    peek(3'd3, v); chk("R3 tx empty again", v, 8'h03);
    chk("R5 period N=2", 32'(fallGap), 6);
    chk("R6 tx irq count", txIrqN, 1);
    chk("R6 rx irq count", rxIrqN, 1);
    chk("R3 frames sent", framesSeen, 1);
    busRead(3'd3, v);
    busWrite(3'd3, 8'h05);
    peek(3'd3, v); chk("R2 rx full cleared", v, 8'h01);

    // R8 back to back, R7 overrun
    expRx = slaveByte;
    handTx(8'h0F, 1'b1);
    repeat (5) @(negedge clk);
    handTx(8'hF0, 1'b1);
    waitFlag(2);
    chk("R8 frame spacing", 32'(frameGap), 50);
    peek(3'd1, v); chk("R7 old byte kept", v, expRx);
    peek(3'd3, v); chk("R7 flags after overrun", v, 8'h07);
    chk("R8 both frames sent", framesSeen, 3);

    // R7 freeze while overrun
    f = fallCnt;
    handTx(8'h77, 1'b0);
    repeat (100) @(negedge clk);
    chk("R7 no frame during overrun", fallCnt, f);
    peek(3'd3, v); chk("R7 tx held", v, 8'h06);

    // R11 clearing enables keeps rx flags, sets tx empty
    busWrite(3'd2, 8'h00);
    peek(3'd3, v); chk("R11 flags after disable", v, 8'h07);
    busRead(3'd3, v);
    busWrite(3'd3, 8'h01);
    peek(3'd3, v); chk("R2 rx flags cleared", v, 8'h01);

    // R9 receive only, N=0
    busWrite(3'd4, 8'h00);
    expRx = slaveByte;
    busWrite(3'd2, 8'h02);
    waitFlag(2);
    peek(3'd1, v); chk("R9 first byte kept", v, expRx);
    peek(3'd3, v); chk("R9 overrun in rx only", v, 8'h07);
    chk("R5 period N=0", 32'(fallGap), 2);

    // R11 abort a running frame
    busWrite(3'd2, 8'h00);
    busRead(3'd3, v);
    busWrite(3'd3, 8'h01);
    busWrite(3'd4, 8'h02);
    busWrite(3'd2, 8'h01);
    handTx(8'h99, 1'b0);
    repeat (10) @(negedge clk);
    busWrite(3'd2, 8'h00);
    chk("R11 sck high after abort", sck, 1'b1);
    f = fallCnt;
    repeat (100) @(negedge clk);
    chk("R11 clock stays idle", fallCnt, f);
    peek(3'd3, v); chk("R11 flags after abort", v, 8'h01);
    chk("R3 scoreboard drained", txQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule